// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital front end of a 10-bit successive-approximation converter. Software writes a control word holding a module enable, a start/busy bit, a result-format select and an interrupt enable. Once started, the block walks a DAC trial code from the most significant bit down, one step per conversion-clock tick. On each tick it reads a single comparator input and keeps or drops the trial bit.

When the last bit is resolved, the block stores the code and presents it as a pair of 8-bit result registers, either left- or right-justified. It clears the busy bit and raises a sticky completion flag. When interrupts are enabled, the flag drives an interrupt/wake request. Software can abandon a conversion at any time. The last good result is then kept, and sampling of the input resumes by itself after a two-tick recovery gap. The analog comparator, the DAC, channel selection and the host interrupt logic sit outside this block.

Top module: `adc_seq`

## Requirements
- R1: A conversion starts only when a control write carries go=1 and enable=1 while the enable register already reads 1, the block is idle and no recovery is pending. A write with enable=0 never starts one.
- R2: On completion, go_o drops to 0, flag_o is set and the stored result takes the new code, all in the same clock edge.
- R3: Starting loads DAC code 0x200. Each tad_tick_i keeps the current trial bit when cmp_i=1 (input at or above the DAC level) and otherwise drops it, then sets the next lower bit. Completion happens on the tenth tick and not earlier, and the stored code equals the analog value.
- R4: flag_o is set by every completion, whatever ie_o is. It is cleared only by a flag_clr_i pulse, and control writes leave it unchanged.
- R5: irq_o is 1 exactly when flag_o and ie_o are both 1.
- R6: A control write with go=0 while busy aborts the conversion. go_o drops, the stored result keeps its previous value, and flag_o is not set.
- R7: A control write with enable=0 while busy aborts the conversion in the same way as R6, and en_o reads 0.
- R8: acq_o is 1 when enabled, idle and not recovering. An abort forces acq_o to 0 for the next two tad_tick_i pulses; it returns to 1 after the second one. Start requests made during that gap are ignored.
- R9: With fmt_o=0, res_hi_o holds result bits 9..2, res_lo_o bits 7..6 hold result bits 1..0, and res_lo_o bits 5..0 read 0.
- R10: With fmt_o=1, res_hi_o bits 1..0 hold result bits 9..8, res_hi_o bits 7..2 read 0, and res_lo_o holds result bits 7..0.
- R11: Reset clears every register (enable, go, format, interrupt enable, flag, result, DAC code) and terminates any conversion in progress.
- R12: A write that sets enable and go together while enable reads 0 sets enable but does not start a conversion.
- R13: A write with go=1 and enable=1 while busy does not disturb the conversion. Its format and interrupt-enable fields still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tad_tick_i | input | 1 | Conversion-clock enable, one pulse per bit period |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_en_i | input | 1 | Write data: module enable |
| ctrl_go_i | input | 1 | Write data: start / abort |
| ctrl_fmt_i | input | 1 | Write data: 0 left-justified, 1 right-justified |
| ctrl_ie_i | input | 1 | Write data: interrupt enable |
| flag_clr_i | input | 1 | Clears the completion flag |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| en_o | output | 1 | Module enable register |
| go_o | output | 1 | Start/busy bit |
| fmt_o | output | 1 | Result format register |
| ie_o | output | 1 | Interrupt enable register |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt / wake request |
| acq_o | output | 1 | Input acquisition active |
| dac_code_o | output | 10 | SAR DAC trial code |
| res_hi_o | output | 8 | Formatted result, high register |
| res_lo_o | output | 8 | Formatted result, low register |

## Verification
A control write is taken at the next rising edge, so go_o, en_o, acq_o and the DAC code are checked one cycle after the strobe. The bench drives inputs and samples on falling edges, which keeps every check in the cycle after the edge it depends on. Completion lands on the edge of the tenth tick. The monitor therefore looks for the falling edge of go_o at the next negative edge and compares both result registers there against a value the driver queued when it started the conversion. The two-tick recovery is checked after each of the two ticks, and the formatting is checked again after each format write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned RES_W     = 10;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned REC_TICKS = 2;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned REC_TICKS = adc_seq_pkg::REC_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tad_tick_i,
  input  logic ctrl_we_i,
  input  logic ctrl_en_i,
  input  logic ctrl_go_i,
  input  logic ctrl_fmt_i,
  input  logic ctrl_ie_i,
  input  logic flag_clr_i,
  input  logic done_i,
  output logic en_o,
  output logic go_o,
  output logic fmt_o,
  output logic ie_o,
  output logic flag_o,
  output logic start_o,
  output logic abort_o,
  output logic acq_o
);
  localparam int unsigned REC_W = $clog2(REC_TICKS + 1);

  logic             en_q, go_q, fmt_q, ie_q, flag_q;
  logic [REC_W-1:0] rec_q;
  logic             rec_busy;

  assign rec_busy = (rec_q != '0);
  // enable must already be set before the write that asks for go
  assign start_o  = ctrl_we_i & ctrl_go_i & ctrl_en_i & en_q & ~go_q & ~rec_busy;
  assign abort_o  = ctrl_we_i & go_q & (~ctrl_go_i | ~ctrl_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      fmt_q  <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      rec_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q  <= ctrl_en_i;
        fmt_q <= ctrl_fmt_i;
        ie_q  <= ctrl_ie_i;
      end
      if (start_o)              go_q <= 1'b1;
      else if (abort_o | done_i) go_q <= 1'b0;
      if (done_i)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (abort_o)                     rec_q <= REC_W'(REC_TICKS);
      else if (tad_tick_i && rec_busy) rec_q <= rec_q - 1'b1;
    end
  end

  assign en_o   = en_q;
  assign go_o   = go_q;
  assign fmt_o  = fmt_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
  assign acq_o  = en_q & ~go_q & ~rec_busy;
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int unsigned RES_W = adc_seq_pkg::RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tad_tick_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned IDX_W = $clog2(RES_W);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] code_q, res_q, trial_mask, kept;

  assign trial_mask = RES_W'(1) << idx_q;
  assign kept       = cmp_i ? code_q : (code_q & ~trial_mask);
  assign done_o     = busy_q & tad_tick_i & ~abort_i & (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      code_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      code_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= IDX_W'(RES_W - 1);
      code_q <= RES_W'(1) << (RES_W - 1);
    end else if (busy_q && tad_tick_i) begin
      if (idx_q == '0) begin
        busy_q <= 1'b0;
        code_q <= '0;
      end else begin
        idx_q  <= idx_q - 1'b1;
        code_q <= kept | (trial_mask >> 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (done_o) res_q <= kept;
  end

  assign dac_code_o = code_q;
  assign result_o   = res_q;
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int unsigned RES_W = adc_seq_pkg::RES_W,
  parameter int unsigned REG_W = adc_seq_pkg::REG_W
) (
  input  logic             fmt_i,
  input  logic [RES_W-1:0] res_i,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o
);
  localparam int unsigned XW  = RES_W - REG_W;
  localparam int unsigned CW  = RES_W + REG_W;

  logic [REG_W-1:0] hi_left, lo_left, hi_right, lo_right;
  logic [CW-1:0]    padded, shifted;

  assign padded   = {res_i, {REG_W{1'b0}}};
  assign shifted  = padded >> XW;
  assign hi_left  = res_i[RES_W-1 -: REG_W];
  assign lo_left  = shifted[REG_W-1:0];
  assign hi_right = REG_W'(res_i >> REG_W);
  assign lo_right = res_i[REG_W-1:0];

  assign hi_o = fmt_i ? hi_right : hi_left;
  assign lo_o = fmt_i ? lo_right : lo_left;
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int unsigned RES_W     = adc_seq_pkg::RES_W,
  parameter int unsigned REG_W     = adc_seq_pkg::REG_W,
  parameter int unsigned REC_TICKS = adc_seq_pkg::REC_TICKS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tad_tick_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_en_i,
  input  logic             ctrl_go_i,
  input  logic             ctrl_fmt_i,
  input  logic             ctrl_ie_i,
  input  logic             flag_clr_i,
  input  logic             cmp_i,
  output logic             en_o,
  output logic             go_o,
  output logic             fmt_o,
  output logic             ie_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             acq_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o
);
  logic             start_w, abort_w, done_w;
  logic [RES_W-1:0] result_w;

  adc_seq_ctrl #(.REC_TICKS(REC_TICKS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tad_tick_i(tad_tick_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_en_i(ctrl_en_i), .ctrl_go_i(ctrl_go_i),
    .ctrl_fmt_i(ctrl_fmt_i), .ctrl_ie_i(ctrl_ie_i), .flag_clr_i(flag_clr_i),
    .done_i(done_w), .en_o(en_o), .go_o(go_o), .fmt_o(fmt_o), .ie_o(ie_o),
    .flag_o(flag_o), .start_o(start_w), .abort_o(abort_w), .acq_o(acq_o)
  );

  adc_sar_core #(.RES_W(RES_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tad_tick_i(tad_tick_i),
    .start_i(start_w), .abort_i(abort_w), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .done_o(done_w), .result_o(result_w)
  );

  adc_result_fmt #(.RES_W(RES_W), .REG_W(REG_W)) u_fmt (
    .fmt_i(fmt_o), .res_i(result_w), .hi_o(res_hi_o), .lo_o(res_lo_o)
  );

  assign irq_o = flag_o & ie_o;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned RES_W = adc_seq_pkg::RES_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tad_tick_i,
  input logic             ctrl_we_i,
  input logic             ctrl_en_i,
  input logic             ctrl_go_i,
  input logic             flag_clr_i,
  input logic             en_o,
  input logic             go_o,
  input logic             ie_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             acq_o,
  input logic             done_i,
  input logic             abort_i,
  input logic [RES_W-1:0] result_i
);
  p_go_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> en_o);
  p_done_effects_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (flag_o && !go_o));
  p_done_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (go_o && tad_tick_i));
  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  p_irq_needs_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && ie_o));
  p_abort_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> ($stable(result_i) && !go_o));
  p_abort_no_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !flag_o) |=> !flag_o);
  p_recover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !acq_o);
  p_joint_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_go_i && !en_o) |=> !go_o);
  p_busy_rewrite_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && ctrl_we_i && ctrl_go_i && ctrl_en_i && !done_i) |=> go_o);
endmodule

bind adc_seq adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tad_tick_i(tad_tick_i),
  .ctrl_we_i(ctrl_we_i), .ctrl_en_i(ctrl_en_i), .ctrl_go_i(ctrl_go_i),
  .flag_clr_i(flag_clr_i), .en_o(en_o), .go_o(go_o), .ie_o(ie_o),
  .flag_o(flag_o), .irq_o(irq_o), .acq_o(acq_o),
  .done_i(done_w), .abort_i(abort_w), .result_i(result_w)
);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tad_tick_i = 1'b0;
  logic       ctrl_we_i = 1'b0, ctrl_en_i = 1'b0, ctrl_go_i = 1'b0;
  logic       ctrl_fmt_i = 1'b0, ctrl_ie_i = 1'b0, flag_clr_i = 1'b0;
  logic       cmp_i;
  logic       en_o, go_o, fmt_o, ie_o, flag_o, irq_o, acq_o;
  logic [9:0] dac_code_o;
  logic [7:0] res_hi_o, res_lo_o;

  logic [9:0] vin = '0;
  int         n_chk = 0, n_bad = 0, cyc = 0;
  bit         finished = 0, abort_pending = 0, go_d = 0;
  logic [9:0] exp_q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  assign cmp_i = (vin >= dac_code_o);

  adc_seq u_adc_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tad_tick_i(tad_tick_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_en_i(ctrl_en_i), .ctrl_go_i(ctrl_go_i),
    .ctrl_fmt_i(ctrl_fmt_i), .ctrl_ie_i(ctrl_ie_i), .flag_clr_i(flag_clr_i),
    .cmp_i(cmp_i), .en_o(en_o), .go_o(go_o), .fmt_o(fmt_o), .ie_o(ie_o),
    .flag_o(flag_o), .irq_o(irq_o), .acq_o(acq_o), .dac_code_o(dac_code_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
  );

  function automatic logic [7:0] exp_hi(logic [9:0] v, logic f);
    return f ? {6'b0, v[9:8]} : v[9:2];
  endfunction
  function automatic logic [7:0] exp_lo(logic [9:0] v, logic f);
    return f ? v[7:0] : {v[1:0], 6'b0};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wr_ctrl(bit en, bit go, bit fmt, bit ie);
    @(negedge clk_i);
    ctrl_we_i = 1; ctrl_en_i = en; ctrl_go_i = go; ctrl_fmt_i = fmt; ctrl_ie_i = ie;
    @(negedge clk_i);
    ctrl_we_i = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tad_tick_i = 1;
      @(negedge clk_i); tad_tick_i = 0;
    end
  endtask

  task automatic clr_flag();
    @(negedge clk_i); flag_clr_i = 1;
    @(negedge clk_i); flag_clr_i = 0;
  endtask

  // driver: start a conversion expected to finish and queue its result
  task automatic start_conv(logic [9:0] v, bit fmt, bit ie);
    vin = v;
    exp_q.push_back(v);
    wr_ctrl(1, 1, fmt, ie);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (go_d && !go_o) begin
      if (abort_pending) abort_pending = 0;
      else if (exp_q.size() == 0) chk(0, "R2 unexpected completion", 1, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(res_hi_o == exp_hi(e, fmt_o), "R2/R3 result high", res_hi_o, exp_hi(e, fmt_o));
        chk(res_lo_o == exp_lo(e, fmt_o), "R2/R3 result low", res_lo_o, exp_lo(e, fmt_o));
        chk(flag_o == 1'b1, "R2 flag on completion", flag_o, 1);
      end
    end
    go_d = go_o;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk({en_o, go_o, fmt_o, ie_o, flag_o, irq_o, acq_o} == 7'b0, "R11 reset ctrl", {en_o, go_o, flag_o}, 0);
    chk({res_hi_o, res_lo_o, dac_code_o} == '0, "R11 reset data", {res_hi_o, res_lo_o}, 0);
    rst_ni = 1;

    // R12 joint enable+go write does not start
    wr_ctrl(1, 1, 0, 0);
    chk(go_o == 0 && en_o == 1, "R12 joint write", {en_o, go_o}, 2);
    chk(acq_o == 1, "R8 acquiring when idle", acq_o, 1);

    // R3 first trial code and tick count
    start_conv(10'h2A5, 0, 0);
    chk(go_o == 1 && dac_code_o == 10'h200, "R3 start code", dac_code_o, 10'h200);
    tick(9);
    chk(go_o == 1, "R3 not done after nine ticks", go_o, 1);
    tick(1);
    chk(go_o == 0 && flag_o == 1, "R4 flag with ie=0", flag_o, 1);
    chk(irq_o == 0, "R5 no irq with ie=0", irq_o, 0);
    chk(res_hi_o == 8'hA9 && res_lo_o == 8'h40, "R9 left justified", {res_hi_o, res_lo_o}, 16'hA940);
    wr_ctrl(1, 0, 1, 0);
    chk(res_hi_o == 8'h02 && res_lo_o == 8'hA5, "R10 right justified", {res_hi_o, res_lo_o}, 16'h02A5);
    chk(flag_o == 1, "R4 control write keeps flag", flag_o, 1);
    clr_flag();
    chk(flag_o == 0, "R4 flag clear", flag_o, 0);

    // R1 go with enable=0 in the write
    wr_ctrl(0, 1, 1, 1);
    chk(go_o == 0, "R1 no start with enable=0", go_o, 0);
    wr_ctrl(1, 0, 1, 1);

    start_conv(10'h000, 1, 1);
    tick(10);
    chk(irq_o == 1, "R5 irq with ie=1", irq_o, 1);
    clr_flag();
    chk(irq_o == 0, "R5 irq drops with flag", irq_o, 0);

    start_conv(10'h3FF, 1, 1);
    tick(10);
    clr_flag();

    // R6 abort by go=0
    vin = 10'h155;
    wr_ctrl(1, 1, 1, 1);
    tick(4);
    abort_pending = 1;
    wr_ctrl(1, 0, 1, 1);
    chk(go_o == 0 && flag_o == 0, "R6 abort no flag", {go_o, flag_o}, 0);
    chk(res_hi_o == 8'h03 && res_lo_o == 8'hFF, "R6 result kept", {res_hi_o, res_lo_o}, 16'h03FF);
    chk(acq_o == 0, "R8 recovery after abort", acq_o, 0);
    wr_ctrl(1, 1, 1, 1);
    chk(go_o == 0, "R8 start ignored in recovery", go_o, 0);
    tick(1);
    chk(acq_o == 0, "R8 still recovering after one tick", acq_o, 0);
    tick(1);
    chk(acq_o == 1, "R8 acquisition resumes", acq_o, 1);

    // R7 abort by clearing enable
    vin = 10'h0F0;
    wr_ctrl(1, 1, 1, 1);
    tick(3);
    abort_pending = 1;
    wr_ctrl(0, 1, 1, 1);
    chk(go_o == 0 && en_o == 0 && flag_o == 0, "R7 enable abort", {en_o, go_o, flag_o}, 0);
    chk(res_hi_o == 8'h03 && res_lo_o == 8'hFF, "R7 result kept", {res_hi_o, res_lo_o}, 16'h03FF);
    tick(2);
    wr_ctrl(1, 0, 1, 1);

    // R13 rewrite go=1 while busy, switching to left justify
    start_conv(10'h1C3, 1, 1);
    tick(5);
    wr_ctrl(1, 1, 0, 1);
    chk(go_o == 1 && fmt_o == 0, "R13 busy rewrite ignored", {go_o, fmt_o}, 2);
    tick(5);
    chk(res_hi_o == 8'h70 && res_lo_o == 8'hC0, "R13/R9 result after rewrite", {res_hi_o, res_lo_o}, 16'h70C0);
    clr_flag();

    // R11 reset mid-conversion
    vin = 10'h2AA;
    wr_ctrl(1, 1, 0, 1);
    tick(3);
    abort_pending = 1;
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i);
    chk({en_o, go_o, flag_o, acq_o} == 4'b0, "R11 reset stops conversion", {en_o, go_o, flag_o}, 0);
    chk({res_hi_o, res_lo_o, dac_code_o} == '0, "R11 reset clears result", {res_hi_o, res_lo_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all queued results seen", exp_q.size(), 0);

    finished = 1;
    summary();
  end
endmodule